// File: doc/BRIEF.md
# Configuration-Tagged Custom Operation Unit

This unit sits beside a processor's register file and executes custom operations. Each operation is named by a numeric configuration ID. A configuration fixes three things: the operation kind, a shift amount, and the list of source registers it reads (up to nine). The unit holds a small number of configurations as resident slots. A decoded custom instruction presents an ID and a destination register. When the ID is resident, the unit reads its operands from a shadow copy of the register file and returns one 32-bit result for writeback on the following cycle.

When the ID is not resident, the unit raises a stall for a fixed, parameterised number of cycles. During that time it fetches the configuration descriptor from its backing store. It then installs the descriptor in a slot and completes the operation. If an empty slot exists it is used; otherwise the least recently used slot is replaced. Only one instruction is in flight at a time. The host keeps the shadow copy current by forwarding its register writes to the unit.

Top module: `rfu_dispatch`

## Requirements
- R1: After reset, `stall` and `res_valid` are low and no configuration is resident, so the first issue of any ID is a miss.
- R2: An issue whose ID is resident yields `res_valid` high in the cycle after the issue, and `stall` stays low.
- R3: An issue whose ID is not resident raises `stall` in the cycle after the issue. `stall` stays high for exactly LOAD_LAT cycles, and `res_valid` is high in the first cycle in which `stall` is low again.
- R4: `res_dst` carries the destination register that was given with the accepted issue.
- R5: Configuration k reads source registers s_i = (3k + 5i + 1) mod 32 for i = 0..8, and uses shift amount sh = ((k >> 2) mod 4) + 1.
- R6: The operation kind is k mod 4. The kinds are: 0 gives r[s0] + (r[s1] << sh); 1 gives r[s0] + r[s1] + r[s2]; 2 gives the XOR of all nine sources; 3 gives (r[s0] - r[s1]) logically shifted right by sh. All arithmetic is modulo 2^32.
- R7: Up to NUM_SLOTS (default 4) configurations stay resident together, and a re-issue of any of them is a hit.
- R8: A miss when all slots are full replaces the least recently used configuration. Both hits and loads count as uses.
- R9: An issue presented while `stall` is high is ignored. It produces no result, does not change the pending destination or the stall length, and does not load its configuration.
- R10: A write on the register write port is visible to every operation issued after the write cycle.
- R11: `res_valid` is a single-cycle pulse for each accepted issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_we | input | 1 | Shadow register write enable |
| rf_waddr | input | AW (5) | Shadow register write index |
| rf_wdata | input | DW (32) | Shadow register write data |
| issue | input | 1 | Custom instruction presented this cycle |
| issue_id | input | ID_W (4) | Configuration ID of the instruction |
| issue_dst | input | AW (5) | Destination register of the instruction |
| stall | output | 1 | High while a configuration is being loaded |
| res_valid | output | 1 | Result valid pulse |
| res_dst | output | AW (5) | Destination register for the result |
| res_data | output | DW (32) | Result value |

## Verification
The bench builds the unit with its default parameters: 32-bit data, 32 registers, 16 configuration IDs, 4 slots and a load latency of 8. With only 16 IDs, every configuration can be swept in both its miss path and its hit path. A long pseudo-random sequence of IDs then drives the four-entry LRU through every eviction order, and the bench checks each result against its own model of residency and arithmetic. The short load window still leaves room to present ignored issues in the middle of a stall.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
  localparam int MAX_SRC = 9;
  localparam int OP_W    = 2;
  localparam int SH_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SHL_ADD = 2'd0,
    OP_ADD3    = 2'd1,
    OP_XOR9    = 2'd2,
    OP_SUB_SHR = 2'd3
  } rfu_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOAD = 1'b1
  } rfu_state_e;
endpackage

// File: rtl/rfu_cfg_store.sv
module rfu_cfg_store
  import rfu_pkg::*;
#(
  parameter int ID_W = 4,
  parameter int AW   = 5
) (
  input  logic [ID_W-1:0]        cfg_id,
  output rfu_op_e                cfg_op,
  output logic [SH_W-1:0]        cfg_sh,
  output logic [MAX_SRC*AW-1:0]  cfg_srcs
);
  logic [ID_W-1:0] id_hi;

  always_comb begin
    id_hi  = cfg_id >> 2;
    cfg_op = rfu_op_e'(cfg_id[1:0]);
    cfg_sh = SH_W'(id_hi[1:0]) + SH_W'(1);
    for (int i = 0; i < MAX_SRC; i++) begin
      cfg_srcs[i*AW +: AW] = AW'(3 * int'(cfg_id) + 5 * i + 1);
    end
  end
endmodule

// File: rtl/rfu_shadow_regs.sv
module rfu_shadow_regs
  import rfu_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [MAX_SRC*AW-1:0]  rd_addr,
  output logic [MAX_SRC*DW-1:0]  rd_data
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar p = 0; p < MAX_SRC; p++) begin : g_rd
    assign rd_data[p*DW +: DW] = mem[rd_addr[p*AW +: AW]];
  end
endmodule

// File: rtl/rfu_slot_table.sv
module rfu_slot_table #(
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 4,
  parameter int DESC_W    = 50
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ID_W-1:0]               lk_id,
  output logic                          lk_hit,
  output logic [DESC_W-1:0]             lk_desc,
  input  logic                          touch_en,
  input  logic                          fill_en,
  input  logic [ID_W-1:0]               fill_id,
  input  logic [DESC_W-1:0]             fill_desc
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic                valid [NUM_SLOTS];
  logic [ID_W-1:0]     tag   [NUM_SLOTS];
  logic [SLOT_W-1:0]   age   [NUM_SLOTS];
  logic [DESC_W-1:0]   desc_mem [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hit_vec;
  logic [SLOT_W-1:0]   hit_slot;
  logic [SLOT_W-1:0]   victim;
  logic [SLOT_W-1:0]   upd_slot;
  logic                upd_en;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    assign hit_vec[s] = valid[s] && (tag[s] == lk_id);
  end

  always_comb begin
    hit_slot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_slot = SLOT_W'(i);
    end
  end

  always_comb begin
    victim = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (age[i] == SLOT_W'(NUM_SLOTS - 1)) victim = SLOT_W'(i);
    end
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!valid[i]) victim = SLOT_W'(i);
    end
  end

  assign lk_hit   = |hit_vec;
  assign lk_desc  = desc_mem[hit_slot];
  assign upd_en   = touch_en || fill_en;
  assign upd_slot = fill_en ? victim : hit_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        valid[i] <= 1'b0;
        age[i]   <= SLOT_W'(i);
      end
    end else begin
      if (fill_en) begin
        valid[victim] <= 1'b1;
        tag[victim]   <= fill_id;
      end
      if (upd_en) begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
          if (SLOT_W'(i) == upd_slot) age[i] <= '0;
          else if (age[i] < age[upd_slot]) age[i] <= age[i] + SLOT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) desc_mem[victim] <= fill_desc;
  end
endmodule

// File: rtl/rfu_datapath.sv
module rfu_datapath
  import rfu_pkg::*;
#(
  parameter int DW = 32
) (
  input  rfu_op_e                op,
  input  logic [SH_W-1:0]        sh,
  input  logic [MAX_SRC*DW-1:0]  opnds,
  output logic [DW-1:0]          result
);
  logic [DW-1:0] x [MAX_SRC];
  logic [DW-1:0] xr;

  for (genvar p = 0; p < MAX_SRC; p++) begin : g_unpack
    assign x[p] = opnds[p*DW +: DW];
  end

  always_comb begin
    xr = '0;
    for (int i = 0; i < MAX_SRC; i++) xr = xr ^ x[i];
  end

  always_comb begin
    unique case (op)
      OP_SHL_ADD: result = x[0] + (x[1] << sh);
      OP_ADD3:    result = x[0] + x[1] + x[2];
      OP_XOR9:    result = xr;
      OP_SUB_SHR: result = (x[0] - x[1]) >> sh;
      default:    result = '0;
    endcase
  end
endmodule

// File: rtl/rfu_dispatch.sv
module rfu_dispatch
  import rfu_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 5,
  parameter int ID_W      = 4,
  parameter int NUM_SLOTS = 4,
  parameter int LOAD_LAT  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rf_we,
  input  logic [AW-1:0]   rf_waddr,
  input  logic [DW-1:0]   rf_wdata,
  input  logic            issue,
  input  logic [ID_W-1:0] issue_id,
  input  logic [AW-1:0]   issue_dst,
  output logic            stall,
  output logic            res_valid,
  output logic [AW-1:0]   res_dst,
  output logic [DW-1:0]   res_data
);
  localparam int SRC_W  = MAX_SRC * AW;
  localparam int DESC_W = OP_W + SH_W + SRC_W;
  localparam int CNT_W  = $clog2(LOAD_LAT + 1);

  rfu_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [ID_W-1:0]   pend_id;
  logic [AW-1:0]     pend_dst;

  logic              lk_hit;
  logic [DESC_W-1:0] slot_desc;
  logic [DESC_W-1:0] store_desc;
  logic [DESC_W-1:0] act_desc;
  rfu_op_e           cs_op;
  logic [SH_W-1:0]   cs_sh;
  logic [SRC_W-1:0]  cs_srcs;
  rfu_op_e           act_op;
  logic [SH_W-1:0]   act_sh;
  logic [SRC_W-1:0]  act_srcs;
  logic [MAX_SRC*DW-1:0] opnds;
  logic [DW-1:0]     dp_result;

  logic accept, hit_go, miss_go, load_done;

  assign accept    = issue && (state == ST_IDLE);
  assign hit_go    = accept && lk_hit;
  assign miss_go   = accept && !lk_hit;
  assign load_done = (state == ST_LOAD) && (cnt == '0);

  rfu_cfg_store #(.ID_W(ID_W), .AW(AW)) u_store (
    .cfg_id   (pend_id),
    .cfg_op   (cs_op),
    .cfg_sh   (cs_sh),
    .cfg_srcs (cs_srcs)
  );

  assign store_desc = {cs_op, cs_sh, cs_srcs};

  rfu_slot_table #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .DESC_W(DESC_W)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .lk_id     (issue_id),
    .lk_hit    (lk_hit),
    .lk_desc   (slot_desc),
    .touch_en  (hit_go),
    .fill_en   (load_done),
    .fill_id   (pend_id),
    .fill_desc (store_desc)
  );

  assign act_desc = (state == ST_LOAD) ? store_desc : slot_desc;
  assign act_op   = rfu_op_e'(act_desc[DESC_W-1 -: OP_W]);
  assign act_sh   = act_desc[DESC_W-OP_W-1 -: SH_W];
  assign act_srcs = act_desc[SRC_W-1:0];

  rfu_shadow_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .wr_en   (rf_we),
    .wr_addr (rf_waddr),
    .wr_data (rf_wdata),
    .rd_addr (act_srcs),
    .rd_data (opnds)
  );

  rfu_datapath #(.DW(DW)) u_dp (
    .op     (act_op),
    .sh     (act_sh),
    .opnds  (opnds),
    .result (dp_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pend_id   <= '0;
      pend_dst  <= '0;
      stall     <= 1'b0;
      res_valid <= 1'b0;
      res_dst   <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= hit_go || load_done;
      if (hit_go) begin
        res_dst  <= issue_dst;
        res_data <= dp_result;
      end
      if (miss_go) begin
        state    <= ST_LOAD;
        cnt      <= CNT_W'(LOAD_LAT - 1);
        stall    <= 1'b1;
        pend_id  <= issue_id;
        pend_dst <= issue_dst;
      end
      if (state == ST_LOAD) begin
        if (cnt == '0) begin
          state    <= ST_IDLE;
          stall    <= 1'b0;
          res_dst  <= pend_dst;
          res_data <= dp_result;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rfu_dispatch_chk.sv
module rfu_dispatch_chk #(
  parameter int AW       = 5,
  parameter int LOAD_LAT = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          issue,
  input logic [AW-1:0] issue_dst,
  input logic          stall,
  input logic          res_valid,
  input logic [AW-1:0] res_dst
);
  localparam int CW = $clog2(LOAD_LAT + 2);

  logic [CW-1:0] run;
  logic [AW-1:0] exp_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= '0;
      exp_dst <= '0;
    end else begin
      if (stall) run <= (run == CW'(LOAD_LAT + 1)) ? run : run + CW'(1);
      else       run <= '0;
      if (issue && !stall) exp_dst <= issue_dst;
    end
  end

  AST_STALL_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> (run == CW'(LOAD_LAT))); // R3
  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst)
    stall |-> (run < CW'(LOAD_LAT))); // R3
  AST_RESULT_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> res_valid); // R3
  AST_ISSUE_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    (issue && !stall) |=> (res_valid || stall)); // R2
  AST_NO_RESULT_IN_STALL: assert property (@(posedge clk) disable iff (rst)
    stall |-> !res_valid); // R9
  AST_RESULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(issue && !stall) || $past(stall))); // R11
  AST_DST_MATCH: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_dst == exp_dst)); // R4
endmodule

bind rfu_dispatch rfu_dispatch_chk #(.AW(AW), .LOAD_LAT(LOAD_LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .issue     (issue),
  .issue_dst (issue_dst),
  .stall     (stall),
  .res_valid (res_valid),
  .res_dst   (res_dst)
);

// File: tb/test_rfu_dispatch.sv
module test_rfu_dispatch;
  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rf_we = 1'b0;
  logic [4:0]  rf_waddr = '0;
  logic [31:0] rf_wdata = '0;
  logic        issue = 1'b0;
  logic [3:0]  issue_id = '0;
  logic [4:0]  issue_dst = '0;
  logic        stall, res_valid;
  logic [4:0]  res_dst;
  logic [31:0] res_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] ref_rf [32];
  int mru [4];

  always #10 clk = ~clk;

  rfu_dispatch #(.LOAD_LAT(LAT)) i_rfu_dispatch (
    .clk(clk), .rst(rst), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .issue(issue), .issue_id(issue_id), .issue_dst(issue_dst),
    .stall(stall), .res_valid(res_valid), .res_dst(res_dst), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_val(int k);
    int s [9];
    int sh;
    logic [31:0] acc;
    sh = ((k >> 2) % 4) + 1;
    for (int i = 0; i < 9; i++) s[i] = (3 * k + 5 * i + 1) % 32;
    case (k % 4)
      0: acc = ref_rf[s[0]] + (ref_rf[s[1]] << sh);
      1: acc = ref_rf[s[0]] + ref_rf[s[1]] + ref_rf[s[2]];
      2: begin
        acc = 32'h0;
        for (int i = 0; i < 9; i++) acc = acc ^ ref_rf[s[i]];
      end
      default: acc = (ref_rf[s[0]] - ref_rf[s[1]]) >> sh;
    endcase
    return acc;
  endfunction

  function automatic bit model_resident(int k);
    for (int i = 0; i < 4; i++) if (mru[i] == k) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_use(input int k);
    int pos;
    pos = 3;
    for (int i = 0; i < 4; i++) if (mru[i] == k) pos = i;
    for (int i = pos; i > 0; i--) mru[i] = mru[i-1];
    mru[0] = k;
  endtask

  task automatic wr_reg(input int a, input logic [31:0] v);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = 5'(a); rf_wdata = v;
    @(negedge clk);
    rf_we = 1'b0;
    ref_rf[a] = v;
  endtask

  // poke_id >= 0: present that ID mid-stall, it must be ignored (R9)
  task automatic run_op(input int k, input int dst, input int poke_id);
    bit hit;
    int n;
    logic [31:0] ev;
    hit = model_resident(k);
    ev  = model_val(k);
    model_use(k);
    @(negedge clk);
    issue = 1'b1; issue_id = 4'(k); issue_dst = 5'(dst);
    @(negedge clk);
    issue = 1'b0;
    chk(stall == !hit, "R7 R8 residency decides stall", 32'(stall), 32'(!hit));
    if (hit) begin
      chk(res_valid == 1'b1, "R2 hit result next cycle", 32'(res_valid), 1);
    end else begin
      chk(res_valid == 1'b0, "R3 no result at stall start", 32'(res_valid), 0);
      n = 0;
      while (stall && n < 100) begin
        n++;
        if (poke_id >= 0 && n == 2) begin
          issue = 1'b1; issue_id = 4'(poke_id); issue_dst = 5'(dst ^ 1);
        end else begin
          issue = 1'b0;
        end
        @(negedge clk);
        if (stall) chk(res_valid == 1'b0, "R9 no result during stall", 32'(res_valid), 0);
      end
      issue = 1'b0;
      chk(n == LAT, "R3 stall length", 32'(n), 32'(LAT));
      chk(res_valid == 1'b1, "R3 result as stall falls", 32'(res_valid), 1);
    end
    chk(res_dst == 5'(dst), "R4 destination echo", 32'(res_dst), 32'(dst));
    chk(res_data == ev, "R5 R6 result value", res_data, ev);
    @(negedge clk);
    chk(res_valid == 1'b0, "R11 single-cycle pulse", 32'(res_valid), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    int k;
    for (int i = 0; i < 4; i++) mru[i] = -1;
    repeat (3) @(negedge clk);
    chk(stall == 1'b0, "R1 stall low in reset", 32'(stall), 0);
    chk(res_valid == 1'b0, "R1 valid low in reset", 32'(res_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(stall == 1'b0 && res_valid == 1'b0, "R1 idle after reset", {stall, res_valid}, 0);

    for (int a = 0; a < 32; a++) wr_reg(a, 32'h9E3779B9 * 32'(a + 1));

    // R1: empty after reset, first issue misses; ID 4 is shift-by-2 then add
    run_op(4, 7, -1);
    run_op(4, 9, -1);

    // R5 R6 R7: every configuration, miss then hit
    for (int id = 0; id < 16; id++) begin
      run_op(id, id + 3, -1);
      run_op(id, 31 - id, -1);
    end

    // R8: LRU ordering with four slots
    run_op(0, 1, -1); run_op(1, 2, -1); run_op(2, 3, -1); run_op(3, 4, -1);
    run_op(0, 5, -1); run_op(5, 6, -1); run_op(1, 7, -1);
    run_op(2, 8, -1); run_op(0, 9, -1); run_op(5, 10, -1);

    // R9: issue during stall ignored, its ID stays absent
    run_op(12, 11, 13);
    chk(model_resident(13) == 1'b0, "R9 poked ID not in model", 0, 0);
    run_op(13, 12, -1);

    // R10: register writes seen by later hits; extreme values
    wr_reg(1, 32'hFFFF_FFFF);
    wr_reg(6, 32'h8000_0001);
    run_op(0, 13, -1);
    wr_reg(1, 32'h0);
    run_op(0, 14, -1);
    for (int a = 0; a < 32; a++) wr_reg(a, (a % 2) ? 32'hFFFF_FFFF : 32'h0);
    for (int id = 0; id < 4; id++) run_op(id, id, -1);

    // pseudo-random sweep
    seed = 32'h1234_5678;
    for (int t = 0; t < 120; t++) begin
      seed = seed * 1103515245 + 12345;
      k = (seed >>> 16) & 15;
      if (k > 9) k = k & 7;
      if ((t % 7) == 3) wr_reg((seed >>> 8) & 31, 32'(seed) ^ 32'hA5A5_0F0F);
      run_op(k, t & 31, ((t % 11) == 5) ? ((k + 9) & 15) : -1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule